// File: doc/BRIEF.md
# Quad-Precision Load-and-Test Unit

This unit takes one 128-bit binary floating-point operand and a 32-bit floating-point control word. It copies the operand to a result register and returns a 2-bit condition code that tells whether the value is zero, negative, positive or not a number. A signaling NaN gets special handling. If its invalid-operation trap is masked, the unit quiets the NaN and records the invalid condition in the control word. If the trap is enabled, the unit leaves the result register alone and raises a data-exception trap. Rounding, arithmetic and instruction decode are outside this unit. Its side of the interrupt path is only the trap strobe and its two codes.

A request is one cycle of `in_valid`, with `opnd` and `cw_in` held for that cycle. The registered outcome appears on the following cycle, and `done` is high for exactly that one cycle. A small two-state machine sequences each operation. `ST_IDLE` is the state with nothing to report. `ST_REPORT` is the cycle in which a result is presented. The named transitions are `accept` (ST_IDLE to ST_REPORT when `in_valid` is high), `chain` (ST_REPORT to ST_REPORT when a new request arrives while one is reported), `settle` (ST_REPORT to ST_IDLE with no new request) and `wait` (ST_IDLE holding with no request). Requests may be issued on consecutive cycles.

Operand layout: bit 127 is the sign. Bits 126:112 are the exponent, and all-ones there marks infinity or NaN. Bits 111:0 are the fraction, and bit 111 is the quiet bit.

Top module: `qlt_unit`

## Requirements
- R1: An operand whose exponent and fraction are both zero gives cc 0, whatever its sign. The result equals the operand, so a negative zero keeps bit 127 set.
- R2: A nonzero operand that is not a NaN gives cc 1 when bit 127 is 1 and cc 2 when it is 0. This includes subnormals and infinity (exponent all-ones, fraction zero). The result equals the operand.
- R3: A NaN (exponent all-ones, fraction nonzero) gives cc 3. A quiet NaN (bit 111 set) is written unchanged and never traps, even when control bit 31 is 1.
- R4: A signaling NaN (bit 111 clear, fraction nonzero) with control bit 31 clear is written with bit 111 set and every other bit unchanged. The cc is 3. The output control word equals the input with bit 23 also set.
- R5: A signaling NaN with control bit 31 set does not write the result, which keeps its previous value. It asserts `trap` with `dxc` = 0x80 and `int_code` = 0x0007. The output control word equals the input with bits 15:8 replaced by 0x80. `cc` keeps its previous value.
- R6: For a non-NaN operand the control-word mask bits 31:27 change neither the result nor the cc, and the output control word equals the input word.
- R7: Each cycle with `in_valid` high produces, one clock later, a one-cycle `done` together with exactly one of `res_we` or `trap`. Without a request, `done`, `res_we` and `trap` stay low, and back-to-back requests each get their own report cycle.
- R8: During and right after reset, `done`, `res_we`, `trap`, `cc`, `res`, `cw_out`, `dxc` and `int_code` are all zero.
- R9: `res` changes only in a cycle where `res_we` is high. Between requests it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe; operand and control word sampled |
| opnd | input | 128 | Floating-point operand |
| cw_in | input | 32 | Floating-point control word |
| done | output | 1 | One-cycle report strobe |
| res | output | 128 | Result register |
| res_we | output | 1 | Result written in this report cycle |
| cc | output | 2 | Condition code |
| cw_out | output | 32 | Updated control word |
| trap | output | 1 | Data-exception trap request |
| dxc | output | 8 | Data-exception code (0x80 with trap, else 0) |
| int_code | output | 16 | Interrupt code (0x0007 with trap, else 0) |

## Verification
A trap report and the acceptance of the next request can fall in the same cycle. That cycle must show the trap with the old cc and old result, while the new request is latched without disturbing them. The bench provokes this by issuing a trapping signaling NaN immediately followed by a positive number on the next cycle. It judges that the first report cycle carries `trap` with the earlier cc and result intact. It then checks that the very next cycle carries `res_we` and the new operand's cc.

// File: rtl/qlt_pkg.sv
package qlt_pkg;
    localparam int OP_W     = 128;
    localparam int EXP_W    = 15;
    localparam int FRAC_W   = 112;
    localparam int CW_W     = 32;
    localparam int DXC_W    = 8;
    localparam int INTC_W   = 16;

    localparam int SIGN_BIT     = OP_W - 1;
    localparam int EXP_HI       = OP_W - 2;
    localparam int QUIET_BIT    = FRAC_W - 1;
    localparam int INV_MASK_BIT = CW_W - 1;
    localparam int INV_FLAG_BIT = 23;
    localparam int DXC_LO       = 8;

    localparam logic [DXC_W-1:0]  DXC_INVALID = 8'h80;
    localparam logic [INTC_W-1:0] INT_DATA    = 16'h0007;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2,
        CC_NAN  = 2'd3
    } cc_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } st_e;

    typedef struct packed {
        logic sgn;
        logic zero;
        logic nan;
        logic snan;
    } cls_t;
endpackage

// File: rtl/qlt_classify.sv
module qlt_classify
    import qlt_pkg::*;
(
    input  logic [OP_W-1:0] opnd,
    output cls_t            cls,
    output logic [OP_W-1:0] quieted
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              frac_nz;

    assign exp_f   = opnd[EXP_HI -: EXP_W];
    assign frac_f  = opnd[FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign frac_nz = |frac_f;

    always_comb begin
        cls.sgn  = opnd[SIGN_BIT];
        cls.zero = (exp_f == '0) && !frac_nz;
        cls.nan  = exp_max && frac_nz;
        cls.snan = exp_max && frac_nz && !frac_f[QUIET_BIT];
    end

    always_comb begin
        quieted            = opnd;
        quieted[QUIET_BIT] = 1'b1;
    end
endmodule

// File: rtl/qlt_resolve.sv
module qlt_resolve
    import qlt_pkg::*;
(
    input  cls_t              cls,
    input  logic [OP_W-1:0]   opnd,
    input  logic [OP_W-1:0]   quieted,
    input  logic [CW_W-1:0]   cw_in,
    input  logic [1:0]        cc_hold,
    output logic [OP_W-1:0]   nxt_res,
    output logic              nxt_we,
    output logic [1:0]        nxt_cc,
    output logic [CW_W-1:0]   nxt_cw,
    output logic              nxt_trap,
    output logic [DXC_W-1:0]  nxt_dxc,
    output logic [INTC_W-1:0] nxt_intc
);
    always_comb begin
        nxt_res  = opnd;
        nxt_we   = 1'b1;
        nxt_cw   = cw_in;
        nxt_trap = 1'b0;
        nxt_dxc  = '0;
        nxt_intc = '0;
        nxt_cc   = CC_POS;
        if (cls.nan) begin
            nxt_cc = CC_NAN;
            if (cls.snan) begin
                if (cw_in[INV_MASK_BIT]) begin
                    nxt_we                         = 1'b0;
                    nxt_trap                       = 1'b1;
                    nxt_cc                         = cc_hold;
                    nxt_dxc                        = DXC_INVALID;
                    nxt_intc                       = INT_DATA;
                    nxt_cw[DXC_LO +: DXC_W]        = DXC_INVALID;
                end else begin
                    nxt_res              = quieted;
                    nxt_cw[INV_FLAG_BIT] = 1'b1;
                end
            end
        end else if (cls.zero) begin
            nxt_cc = CC_ZERO;
        end else if (cls.sgn) begin
            nxt_cc = CC_NEG;
        end else begin
            nxt_cc = CC_POS;
        end
    end
endmodule

// File: rtl/qlt_ctrl.sv
module qlt_ctrl
    import qlt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic accept,
    output logic done
);
    st_e state_q;
    st_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;   // accept / wait
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;   // chain / settle
            default:   state_d = ST_IDLE;
        endcase
    end

    assign accept = rst_n && in_valid;
    assign done   = (state_q == ST_REPORT);
endmodule

// File: rtl/qlt_unit.sv
module qlt_unit
    import qlt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   opnd,
    input  logic [CW_W-1:0]   cw_in,
    output logic              done,
    output logic [OP_W-1:0]   res,
    output logic              res_we,
    output logic [1:0]        cc,
    output logic [CW_W-1:0]   cw_out,
    output logic              trap,
    output logic [DXC_W-1:0]  dxc,
    output logic [INTC_W-1:0] int_code
);
    cls_t              cls;
    logic [OP_W-1:0]   quieted;
    logic [OP_W-1:0]   nxt_res;
    logic              nxt_we;
    logic [1:0]        nxt_cc;
    logic [CW_W-1:0]   nxt_cw;
    logic              nxt_trap;
    logic [DXC_W-1:0]  nxt_dxc;
    logic [INTC_W-1:0] nxt_intc;
    logic              accept;

    logic [OP_W-1:0]   res_q;
    logic              we_q;
    logic [1:0]        cc_q;
    logic [CW_W-1:0]   cw_q;
    logic              trap_q;
    logic [DXC_W-1:0]  dxc_q;
    logic [INTC_W-1:0] intc_q;

    qlt_classify u_cls (
        .opnd    (opnd),
        .cls     (cls),
        .quieted (quieted)
    );

    qlt_resolve u_res (
        .cls      (cls),
        .opnd     (opnd),
        .quieted  (quieted),
        .cw_in    (cw_in),
        .cc_hold  (cc_q),
        .nxt_res  (nxt_res),
        .nxt_we   (nxt_we),
        .nxt_cc   (nxt_cc),
        .nxt_cw   (nxt_cw),
        .nxt_trap (nxt_trap),
        .nxt_dxc  (nxt_dxc),
        .nxt_intc (nxt_intc)
    );

    qlt_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .accept   (accept),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            we_q   <= 1'b0;
            cc_q   <= CC_ZERO;
            cw_q   <= '0;
            trap_q <= 1'b0;
            dxc_q  <= '0;
            intc_q <= '0;
        end else if (accept) begin
            if (nxt_we) res_q <= nxt_res;
            we_q   <= nxt_we;
            cc_q   <= nxt_cc;
            cw_q   <= nxt_cw;
            trap_q <= nxt_trap;
            dxc_q  <= nxt_dxc;
            intc_q <= nxt_intc;
        end else begin
            we_q   <= 1'b0;
            trap_q <= 1'b0;
            dxc_q  <= '0;
            intc_q <= '0;
        end
    end

    assign res      = res_q;
    assign res_we   = we_q;
    assign cc       = cc_q;
    assign cw_out   = cw_q;
    assign trap     = trap_q;
    assign dxc      = dxc_q;
    assign int_code = intc_q;
endmodule

// File: rtl/qlt_unit_chk.sv
module qlt_unit_chk
    import qlt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              done,
    input logic [OP_W-1:0]   res,
    input logic              res_we,
    input logic [1:0]        cc,
    input logic [CW_W-1:0]   cw_out,
    input logic              trap,
    input logic [DXC_W-1:0]  dxc,
    input logic [INTC_W-1:0] int_code
);
    a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);

    a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done);

    a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (res_we ^ trap));

    a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!res_we && !trap));

    a_r5_trap_codes: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (dxc == DXC_INVALID && int_code == INT_DATA
                  && cw_out[DXC_LO +: DXC_W] == DXC_INVALID));

    a_r5_cc_held: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> $stable(cc));

    a_r9_res_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !res_we |-> $stable(res));

    a_r3_nan_written_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && cc == CC_NAN) |-> (res[QUIET_BIT] && (&res[EXP_HI -: EXP_W])));
endmodule

bind qlt_unit qlt_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .done     (done),
    .res      (res),
    .res_we   (res_we),
    .cc       (cc),
    .cw_out   (cw_out),
    .trap     (trap),
    .dxc      (dxc),
    .int_code (int_code)
);

// File: tb/qlt_unit_bench.sv
module qlt_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] opnd = '0;
    logic [31:0]  cw_in = '0;
    logic         done;
    logic [127:0] res;
    logic         res_we;
    logic [1:0]   cc;
    logic [31:0]  cw_out;
    logic         trap;
    logic [7:0]   dxc;
    logic [15:0]  int_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic finished = 1'b0;

    logic [127:0] exp_res = '0;
    logic [1:0]   exp_cc = 2'd0;

    always #2 clk = ~clk;

    qlt_unit u_qlt_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opnd(opnd), .cw_in(cw_in),
        .done(done), .res(res), .res_we(res_we), .cc(cc), .cw_out(cw_out),
        .trap(trap), .dxc(dxc), .int_code(int_code)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    // drive one request; returns at the negedge where its report is visible
    task automatic issue(input logic [127:0] op, input logic [31:0] cw);
        @(negedge clk);
        in_valid = 1'b1; opnd = op; cw_in = cw;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [127:0] r, input logic [1:0] c,
                                input logic [31:0] w);
        check({req, " done"}, done, 1);
        check({req, " we"}, res_we, 1);
        check({req, " trap"}, trap, 0);
        check({req, " res"}, res, r);
        check({req, " cc"}, cc, c);
        check({req, " cw"}, cw_out, w);
        exp_res = r; exp_cc = c;
    endtask

    task automatic t_reset();
        check("R8 done", done, 0);
        check("R8 we", res_we, 0);
        check("R8 trap", trap, 0);
        check("R8 cc", cc, 0);
        check("R8 res", res, 0);
        check("R8 cw", cw_out, 0);
        check("R8 dxc", dxc, 0);
        check("R8 int", int_code, 0);
    endtask

    task automatic t_zero();
        issue(128'h8000_0000_0000_0000_0000_0000_0000_0000, 32'hF800_0000);
        expect_write("R1 neg zero", 128'h8000_0000_0000_0000_0000_0000_0000_0000, 2'd0, 32'hF800_0000);
        issue(128'h0, 32'h0);
        expect_write("R1 pos zero", 128'h0, 2'd0, 32'h0);
    endtask

    task automatic t_signed();
        issue(128'h4001_0000_0000_0000_0000_0000_0000_0000, 32'hF800_0000);
        expect_write("R2 R6 plus four", 128'h4001_0000_0000_0000_0000_0000_0000_0000, 2'd2, 32'hF800_0000);
        issue(128'hC001_0000_0000_0000_0000_0000_0000_0000, 32'hF800_0000);
        expect_write("R2 R6 minus four", 128'hC001_0000_0000_0000_0000_0000_0000_0000, 2'd1, 32'hF800_0000);
        issue(128'h4001_0000_0000_0000_0000_0000_0000_0000, 32'h0);
        expect_write("R6 unmasked", 128'h4001_0000_0000_0000_0000_0000_0000_0000, 2'd2, 32'h0);
        issue(128'h7FFF_0000_0000_0000_0000_0000_0000_0000, 32'h8000_0000);
        expect_write("R2 plus inf", 128'h7FFF_0000_0000_0000_0000_0000_0000_0000, 2'd2, 32'h8000_0000);
        issue(128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 32'h8000_0000);
        expect_write("R2 minus inf", 128'hFFFF_0000_0000_0000_0000_0000_0000_0000, 2'd1, 32'h8000_0000);
        issue(128'h1, 32'h0);
        expect_write("R2 subnormal", 128'h1, 2'd2, 32'h0);
    endtask

    task automatic t_qnan();
        issue(128'h7FFF_8000_0000_0000_0000_0000_0000_0DEF, 32'h8000_0000);
        expect_write("R3 qnan", 128'h7FFF_8000_0000_0000_0000_0000_0000_0DEF, 2'd3, 32'h8000_0000);
        check("R3 qnan dxc", dxc, 0);
    endtask

    task automatic t_snan_masked();
        issue(128'hFFFF_0000_0000_0000_0000_0000_0000_0123, 32'h7800_0000);
        expect_write("R4 snan quieted", 128'hFFFF_8000_0000_0000_0000_0000_0000_0123, 2'd3, 32'h7880_0000);
    endtask

    task automatic t_snan_trap();
        logic [127:0] old_res;
        logic [1:0]   old_cc;
        issue(128'h4001_0000_0000_0000_0000_0000_0000_0000, 32'h0);
        expect_write("R5 setup", 128'h4001_0000_0000_0000_0000_0000_0000_0000, 2'd2, 32'h0);
        old_res = exp_res; old_cc = exp_cc;
        issue(128'h7FFF_0000_0000_0000_0000_0000_0000_0ABC, 32'h8000_0000);
        check("R5 done", done, 1);
        check("R5 trap", trap, 1);
        check("R5 no write", res_we, 0);
        check("R5 res kept", res, old_res);
        check("R5 cc kept", cc, old_cc);
        check("R5 dxc", dxc, 8'h80);
        check("R5 int code", int_code, 16'h0007);
        check("R5 cw", cw_out, 32'h8000_8000);
    endtask

    task automatic t_idle_hold();
        logic [127:0] held;
        held = exp_res;
        repeat (3) begin
            @(negedge clk);
            opnd = ~opnd;
            check("R7 idle done", done, 0);
            check("R7 idle we", res_we, 0);
            check("R7 idle trap", trap, 0);
            check("R9 res held", res, held);
        end
    endtask

    task automatic t_back_to_back();
        issue(128'hC001_0000_0000_0000_0000_0000_0000_0000, 32'h0);
        expect_write("R7 pre", 128'hC001_0000_0000_0000_0000_0000_0000_0000, 2'd1, 32'h0);
        @(negedge clk);
        in_valid = 1'b1; opnd = 128'h7FFF_0000_0000_0000_0000_0000_0000_0001; cw_in = 32'h8000_0000;
        @(negedge clk);
        opnd = 128'h3FFF_0000_0000_0000_0000_0000_0000_0000; cw_in = 32'h0;
        check("R7 chain trap", trap, 1);
        check("R7 chain done", done, 1);
        check("R5 chain cc kept", cc, 2'd1);
        check("R5 chain res kept", res, 128'hC001_0000_0000_0000_0000_0000_0000_0000);
        @(negedge clk);
        in_valid = 1'b0;
        expect_write("R7 chain second", 128'h3FFF_0000_0000_0000_0000_0000_0000_0000, 2'd2, 32'h0);
        @(negedge clk);
        check("R7 settle done", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero();
        t_signed();
        t_qnan();
        t_snan_masked();
        t_snan_trap();
        t_idle_hold();
        t_back_to_back();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule